// File: doc/BRIEF.md
# Configuration Space Presence Scanner

This controller decides whether direct configuration-space access on a host bus looks usable. On a start pulse it walks every device slot of bus 0, function 0, in ascending order, and issues 2-byte configuration reads through a generic request/response master port. For each slot it first asks for the class/subclass word. If that does not identify a host bridge or a display controller, it asks for the vendor ID and compares it against a parameter list of trusted vendors.

The first slot that matches either way ends the scan with a pass verdict and the number of the slot. A read that comes back with its success flag low counts as a non-match, and the walk simply moves on. If every slot fails, the scan ends with a fail verdict. The verdict stays on the outputs until software pulses start again. A start pulse that arrives while a scan is running is ignored.

Top module: `cfg_probe_scan`

## Requirements
- R1: A start pulse while idle or finished begins a scan, and done and pass read 0 one cycle later. A start pulse during a scan has no effect: the walk continues without going back to slot 0.
- R2: Every request carries bus 0, function 0 and size code 1, where size code value n means n+1 bytes. Device numbers are visited in ascending order starting at 0, and no slot is skipped.
- R3: The first request for each slot uses register offset 0x0A (class/subclass). A second request for the same slot, at offset 0x00 (vendor ID), is made only when the class check of that slot failed.
- R4: A class response passes when its success flag is 1 and the 16-bit data (bits 7:0 are the lower-addressed byte) equals 0x0600 or 0x0300.
- R5: A vendor response passes when its success flag is 1 and the data equals one entry of the vendor list parameter (default 0x8086 and 0x0E11).
- R6: A response whose success flag is 0 is a non-match whatever its data, and the scan carries on to the next request.
- R7: The cycle after the first passing response, done=1, pass=1 and found_dev holds that slot number. No further request is issued.
- R8: If slot 31 also fails, the cycle after its last response done=1, pass=0 and found_dev=0.
- R9: While rd_valid is 1 and rd_ready is 0, the request stays asserted and its fields stay unchanged. Only one request is outstanding at a time.
- R10: done, pass and found_dev hold their values until the next start pulse. No request is made while done is 1.
- R11: After reset, done=0, pass=0 and rd_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_bus | output | 8 | Bus number of the request |
| rd_dev | output | 5 | Device number of the request |
| rd_fn | output | 3 | Function number of the request |
| rd_ofs | output | 8 | Register offset of the request |
| rd_size | output | 2 | Access size code (bytes minus one) |
| rsp_valid | input | 1 | Read response valid |
| rsp_ok | input | 1 | Read succeeded |
| rsp_data | input | 16 | Read data, little-endian |
| done | output | 1 | Scan finished |
| pass | output | 1 | A slot matched |
| found_dev | output | 5 | Matching slot number, 0 on fail |

## Verification
The verdict is due exactly one cycle after the response that decides it. The bench marks the negedge where it drives that response and checks done, pass and found_dev at the following negedge, and it also confirms that done is still 0 while the deciding response is on the bus. The clearing of done and pass is due one cycle after the start pulse and is checked at the negedge just after the edge that sampled start. Each request is checked at the negedge after its handshake edge, against a model of the slot walk built from the requirements. That model sets the expected slot, offset and count of every read.

// File: rtl/cfg_probe_pkg.sv
package cfg_probe_pkg;

    typedef logic [15:0] id16_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASK,
        ST_WAIT,
        ST_FIN
    } scan_state_e;

    typedef enum logic {
        PH_CLASS  = 1'b0,
        PH_VENDOR = 1'b1
    } probe_phase_e;

    localparam logic [7:0] OFS_CLASS  = 8'h0A;
    localparam logic [7:0] OFS_VENDOR = 8'h00;
    localparam logic [1:0] SIZE_HALF  = 2'd1;

    function automatic logic slot_accept(input logic ok, input probe_phase_e ph,
                                         input logic cls_hit, input logic ven_hit);
        return ok && ((ph == PH_CLASS) ? cls_hit : ven_hit);
    endfunction

    function automatic logic [7:0] phase_offset(input probe_phase_e ph);
        return (ph == PH_CLASS) ? OFS_CLASS : OFS_VENDOR;
    endfunction

endpackage

// File: rtl/cfg_probe_match.sv
module cfg_probe_match
    import cfg_probe_pkg::*;
#(
    parameter int N = 2,
    parameter logic [N-1:0][15:0] LIST = '0
) (
    input  id16_t value,
    output logic  hit
);
    logic [N-1:0] each;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign each[i] = (value == LIST[i]);
    end

    assign hit = |each;

endmodule

// File: rtl/cfg_probe_seq.sv
module cfg_probe_seq
    import cfg_probe_pkg::*;
#(
    parameter int DEV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_ready,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic             cls_hit,
    input  logic             ven_hit,
    output logic             req_valid,
    output logic [DEV_W-1:0] req_dev,
    output probe_phase_e     req_phase,
    output logic             done,
    output logic             pass,
    output logic [DEV_W-1:0] found_dev
);
    localparam int NUM_SLOTS = 1 << DEV_W;
    localparam logic [DEV_W-1:0] LAST_SLOT = DEV_W'(NUM_SLOTS - 1);

    scan_state_e      st;
    probe_phase_e     ph;
    logic [DEV_W-1:0] dev;
    logic             hit;

    assign hit       = slot_accept(rsp_ok, ph, cls_hit, ven_hit);
    assign req_valid = (st == ST_ASK);
    assign req_dev   = dev;
    assign req_phase = ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_CLASS;
            dev       <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            found_dev <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        st        <= ST_ASK;
                        ph        <= PH_CLASS;
                        dev       <= '0;
                        done      <= 1'b0;
                        pass      <= 1'b0;
                        found_dev <= '0;
                    end
                end
                ST_ASK: begin
                    if (rd_ready) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (hit) begin
                            st        <= ST_FIN;
                            done      <= 1'b1;
                            pass      <= 1'b1;
                            found_dev <= dev;
                        end else if (ph == PH_CLASS) begin
                            ph <= PH_VENDOR;
                            st <= ST_ASK;
                        end else if (dev == LAST_SLOT) begin
                            st        <= ST_FIN;
                            done      <= 1'b1;
                            pass      <= 1'b0;
                            found_dev <= '0;
                        end else begin
                            dev <= dev + 1'b1;
                            ph  <= PH_CLASS;
                            st  <= ST_ASK;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: a stalled request keeps its device and phase
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rd_ready |=> req_valid && $stable(req_dev) && $stable(req_phase));

    // R7 / R8: completion only follows a response
    a_r7_done_after_rsp: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(rsp_valid));

    // R10: verdict held while no start arrives
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(pass) && $stable(found_dev));

    // R10: no request while finished
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    // R7: pass implies done
    a_r7_pass_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

endmodule

// File: rtl/cfg_probe_scan.sv
module cfg_probe_scan
    import cfg_probe_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int OFS_W  = 8,
    parameter int N_CLS  = 2,
    parameter logic [N_CLS-1:0][15:0] CLS_LIST = {16'h0300, 16'h0600},
    parameter int N_VEN  = 2,
    parameter logic [N_VEN-1:0][15:0] VEN_LIST = {16'h0E11, 16'h8086}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [BUS_W-1:0] rd_bus,
    output logic [DEV_W-1:0] rd_dev,
    output logic [FN_W-1:0]  rd_fn,
    output logic [OFS_W-1:0] rd_ofs,
    output logic [1:0]       rd_size,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic [15:0]      rsp_data,
    output logic             done,
    output logic             pass,
    output logic [DEV_W-1:0] found_dev
);
    logic         cls_hit;
    logic         ven_hit;
    probe_phase_e phase;

    cfg_probe_match #(.N(N_CLS), .LIST(CLS_LIST)) u_cls (
        .value (rsp_data),
        .hit   (cls_hit)
    );

    cfg_probe_match #(.N(N_VEN), .LIST(VEN_LIST)) u_ven (
        .value (rsp_data),
        .hit   (ven_hit)
    );

    cfg_probe_seq #(.DEV_W(DEV_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_ready  (rd_ready),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .cls_hit   (cls_hit),
        .ven_hit   (ven_hit),
        .req_valid (rd_valid),
        .req_dev   (rd_dev),
        .req_phase (phase),
        .done      (done),
        .pass      (pass),
        .found_dev (found_dev)
    );

    assign rd_bus  = '0;
    assign rd_fn   = '0;
    assign rd_size = SIZE_HALF;
    assign rd_ofs  = OFS_W'(phase_offset(phase));

    // R9: offset stays put while the request is stalled
    a_r9_ofs_hold: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> $stable(rd_ofs));

    // R7: the verdict is never pass with no accepted response before it
    a_r7_pass_src: assert property (@(posedge clk) disable iff (rst)
        $rose(pass) |-> $past(rsp_valid && rsp_ok));

endmodule

// File: tb/sim_cfg_probe_scan.sv
`timescale 1ns/1ps
module sim_cfg_probe_scan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_bus;
    logic [4:0]  rd_dev;
    logic [2:0]  rd_fn;
    logic [7:0]  rd_ofs;
    logic [1:0]  rd_size;
    logic        rsp_valid = 1'b0;
    logic        rsp_ok = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        done;
    logic        pass;
    logic [4:0]  found_dev;

    always #2 clk = ~clk;

    cfg_probe_scan u0 (
        .clk(clk), .rst(rst), .start(start),
        .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_bus(rd_bus), .rd_dev(rd_dev), .rd_fn(rd_fn),
        .rd_ofs(rd_ofs), .rd_size(rd_size),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .done(done), .pass(pass), .found_dev(found_dev)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input logic cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // handshake capture
    int         hs_count = 0;
    logic [7:0] cap_bus, cap_ofs;
    logic [4:0] cap_dev;
    logic [2:0] cap_fn;
    logic [1:0] cap_size;

    always @(posedge clk) begin
        if (!rst && rd_valid && rd_ready) begin
            hs_count <= hs_count + 1;
            cap_bus  <= rd_bus;
            cap_dev  <= rd_dev;
            cap_fn   <= rd_fn;
            cap_ofs  <= rd_ofs;
            cap_size <= rd_size;
        end
    end

    // scan model
    int   scn = 0;
    int   m_dev = 0;
    int   m_ph = 0;
    bit   m_end = 1'b1;
    int   m_reqs = 0;
    bit   due = 1'b0;
    bit   due_pass = 1'b0;
    int   due_slot = 0;
    int   seen = 0;
    bit   pend = 1'b0;
    int   dly = 0;

    function automatic logic [16:0] tbl(input int s, input int d, input int ph);
        logic [16:0] r;
        r = (ph == 0) ? {1'b1, 16'h0280} : {1'b1, 16'h1AB3};
        case (s)
            1: if (d == 0 && ph == 0) r = {1'b1, 16'h0600};
            2: if (d == 31 && ph == 0) r = {1'b1, 16'h0300};
            3: begin
                if (d == 12) r = (ph == 0) ? {1'b0, 16'h0600} : {1'b0, 16'h8086};
                if (d == 20 && ph == 1) r = {1'b1, 16'h0E11};
            end
            4: begin
                if (d == 2) r = (ph == 0) ? {1'b1, 16'h0006} : {1'b1, 16'h8680};
                if (d == 9 && ph == 0) r = {1'b1, 16'h0300};
            end
            5: r = (ph == 0) ? {1'b0, 16'h0600} : {1'b0, 16'h8086};
            default: begin
                if (s >= 100 && d == s - 100 && ph == 1)
                    r = {1'b1, (d % 2 == 0) ? 16'h8086 : 16'h0E11};
            end
        endcase
        return r;
    endfunction

    always @(negedge clk) begin
        logic [16:0] rv;
        bit hit;
        cyc++;
        rd_ready  = (cyc % 3) != 2;
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_data  = '0;
        if (due) begin
            due = 1'b0;
            chk(done == 1'b1, "R7/R8 done one cycle after last response", done, 1);
            chk(pass == due_pass, "R7/R8 pass verdict", pass, due_pass);
            chk(found_dev == 5'(due_slot), "R7/R8 found_dev", found_dev, due_slot);
        end
        if (hs_count != seen) begin
            seen = hs_count;
            m_reqs++;
            chk(!m_end, "R10 no request after verdict", m_end, 0);
            chk(cap_bus == 0 && cap_fn == 0 && cap_size == 2'd1,
                "R2 bus/fn/size", {cap_bus, cap_fn, cap_size}, 1);
            chk(cap_dev == 5'(m_dev), "R2 device order", cap_dev, m_dev);
            chk(cap_ofs == ((m_ph == 0) ? 8'h0A : 8'h00), "R3 offset", cap_ofs,
                (m_ph == 0) ? 8'h0A : 8'h00);
            pend = 1'b1;
            dly  = 2;
        end else if (pend) begin
            if (dly > 1) dly--;
            else begin
                pend = 1'b0;
                rv = tbl(scn, m_dev, m_ph);
                rsp_valid = 1'b1;
                rsp_ok    = rv[16];
                rsp_data  = rv[15:0];
                chk(done == 1'b0, "R7 done low before deciding response", done, 0);
                if (m_ph == 0) hit = rv[16] && (rv[15:0] == 16'h0600 || rv[15:0] == 16'h0300);
                else           hit = rv[16] && (rv[15:0] == 16'h8086 || rv[15:0] == 16'h0E11);
                if (hit) begin
                    m_end = 1'b1; due = 1'b1; due_pass = 1'b1; due_slot = m_dev;
                end else if (m_ph == 0) begin
                    m_ph = 1;
                end else if (m_dev == 31) begin
                    m_end = 1'b1; due = 1'b1; due_pass = 1'b0; due_slot = 0;
                end else begin
                    m_dev++; m_ph = 0;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_scan(input int s, input bit exp_pass, input int exp_slot,
                            input int exp_reqs, input bit mid_start);
        int t;
        scn = s; m_dev = 0; m_ph = 0; m_reqs = 0; m_end = 1'b0;
        pulse_start();
        chk(done == 1'b0 && pass == 1'b0, "R1 verdict cleared after start", {done, pass}, 0);
        if (mid_start) begin
            repeat (30) @(negedge clk);
            pulse_start();
        end
        t = 0;
        while (!(m_end && !due) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) chk(1'b0, "watchdog scan timeout", t, 0);
        @(negedge clk);
        chk(pass == exp_pass, "R4/R5/R6 scenario verdict", pass, exp_pass);
        chk(found_dev == 5'(exp_slot), "R7 scenario slot", found_dev, exp_slot);
        chk(m_reqs == exp_reqs, "R3/R1 request count", m_reqs, exp_reqs);
        repeat (6) @(negedge clk);
        chk(done && pass == exp_pass && found_dev == 5'(exp_slot) && !rd_valid,
            "R10 verdict held", {done, pass, found_dev}, {1'b1, exp_pass, 5'(exp_slot)});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && pass == 0 && rd_valid == 0, "R11 reset state",
            {done, pass, rd_valid}, 0);
        run_scan(0, 1'b0, 0, 64, 1'b1);   // R8, R1 mid-scan start ignored
        run_scan(1, 1'b1, 0, 1, 1'b0);    // R4 host bridge class at slot 0
        run_scan(2, 1'b1, 31, 63, 1'b0);  // R4 display class at last slot
        run_scan(3, 1'b1, 20, 42, 1'b0);  // R6 failed reads skipped, R5
        run_scan(4, 1'b1, 9, 19, 1'b0);   // R4/R5 byte-swapped values rejected
        run_scan(5, 1'b0, 0, 64, 1'b0);   // R6 all reads failed
        for (int k = 0; k < 32; k++)
            run_scan(100 + k, 1'b1, k, 2 * k + 2, 1'b0); // R5 sweep of slots
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog global timeout actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule